// File: doc/BRIEF.md
# PCI Shared-Line Interrupt Router

This block collects the INTx pins of several PCI slots, folds them onto four shared interrupt lines, and steers each shared line onto one of sixteen legacy interrupt-controller inputs. Before folding, each slot's pins are rotated by the slot's device number. This spreads the common "pin A" users across all four lines.

Each shared line has one 8-bit routing byte. Software writes these bytes through a dword-wide configuration port that has per-byte enables. A routing value from 0 to 15 selects a destination input. Any larger value parks the line so that it drives nothing.

A destination output is the wired-OR of every shared line steered to it. The block keeps a 16×4 matrix of routed levels:
- When a single line changes level, only that line's cell is updated, under its current route.
- Any write that lands on a routing byte clears the whole matrix and rebuilds it from the live levels of all four lines, using the new routes.

The matrix update is decided each cycle by one of three named update kinds:
- `UPD_HOLD`: nothing changed.
- `UPD_LINE`: one or more line levels differ from the previous cycle and no routing write is present.
- `UPD_REBUILD`: a routing byte is being written; this takes priority over `UPD_LINE`.

Top module: `pirq_router`

## Requirements
- R1: After reset all four routing bytes hold 0x80, every destination output is low, and the route query reports every line as disabled.
- R2: A write whose byte address is exactly 0x60 updates the routing byte of line k (line A = byte lane 0, bits 7:0; B = lane 1; C = lane 2; D = lane 3, bits 31:24) only when byte enable k is set. Reading address 0x60 returns {D,C,B,A}. Reading any other address returns zero.
- R3: A routing byte of 16 or more disables its line: the line drives no output, and the query reports enable 0 with irq 5'h1F (−1). A value of 0 to 15 selects that destination; 15 is valid.
- R4: Slot s has device number s+1. Its pin i (A=0..D=3) is input bit s*4+i, and it feeds line (i + device − 1) mod 4. A line's level is the OR of all pins that feed it.
- R5: Output k is high exactly when at least one enabled line routed to k is high. Two lines sharing an output keep it high until both are low.
- R6: A change of pin level shows on the outputs after the first rising clock edge that follows it.
- R7: After a write to any routing byte, all outputs reflect the new routing and the present line levels from the first rising edge after the write. The old destination drops in that same cycle.
- R8: Writes to other addresses, and writes to 0x60 with no byte enable set, change neither the routing bytes nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (read and write) |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data, four byte lanes |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| intx_in | input | 16 | INTx pins, four per slot |
| route_sel | input | 2 | Line selected for the route query |
| route_on | output | 1 | Selected line is enabled |
| route_irq | output | 5 | Destination of the selected line, all ones when disabled |
| irq_out | output | 16 | Interrupt-controller input levels |

## Verification
Destination outputs are due at the first rising edge after a pin change or a routing write. The readback port and the route query are combinational from the routing registers, so they show the value set by the previous rising edge. The bench drives every stimulus on a falling edge and pushes the expected output vector into a queue, tagged with the next cycle number. A monitor pops it on the falling edge after that rising edge. Readback and query values are compared 1 ns after the drive, within the same low phase, against a model that absorbs the write only afterwards.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
    localparam int          PIRQ_COUNT  = 4;
    localparam int          IRQ_COUNT   = 16;
    localparam logic [7:0]  ROUTE_RESET = 8'h80;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_LINE,
        UPD_REBUILD
    } upd_kind_e;
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_PIRQ  = 4,
    parameter int DEV_BASE  = 1
) (
    input  logic [NUM_SLOTS*NUM_PIRQ-1:0] intx_in,
    output logic [NUM_PIRQ-1:0]           pirq_lvl
);
    localparam int PINS = NUM_SLOTS * NUM_PIRQ;

    // Pins of every slot whose rotated position lands on line p.
    function automatic logic [PINS-1:0] pin_mask(int p);
        logic [PINS-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int i = 0; i < NUM_PIRQ; i++) begin
                if (((i + DEV_BASE + s + NUM_PIRQ - 1) % NUM_PIRQ) == p)
                    m[s*NUM_PIRQ+i] = 1'b1;
            end
        end
        return m;
    endfunction

    for (genvar gp = 0; gp < NUM_PIRQ; gp++) begin : g_line
        assign pirq_lvl[gp] = |(intx_in & pin_mask(gp));
    end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int         NUM_PIRQ   = PIRQ_COUNT,
    parameter logic [7:0] ROUTE_ADDR = 8'h60
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [7:0]               cfg_addr,
    input  logic [3:0]               cfg_be,
    input  logic [31:0]              cfg_wdata,
    output logic [NUM_PIRQ-1:0][7:0] route_q,
    output logic [NUM_PIRQ-1:0][7:0] route_d,
    output logic                     route_hit,
    output logic [31:0]              cfg_rdata
);
    logic                dw_sel;
    logic [NUM_PIRQ-1:0] lane_wr;

    assign dw_sel = (cfg_addr == ROUTE_ADDR);

    for (genvar gp = 0; gp < NUM_PIRQ; gp++) begin : g_lane
        assign lane_wr[gp] = cfg_wr && dw_sel && cfg_be[gp];
        assign route_d[gp] = lane_wr[gp] ? cfg_wdata[gp*8 +: 8] : route_q[gp];
    end

    assign route_hit = |lane_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            route_q <= {NUM_PIRQ{ROUTE_RESET}};
        else
            route_q <= route_d;
    end

    assign cfg_rdata = dw_sel ? 32'(route_q) : 32'h0;
endmodule

// File: rtl/pirq_level_matrix.sv
module pirq_level_matrix
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ = PIRQ_COUNT,
    parameter int NUM_IRQ  = IRQ_COUNT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PIRQ-1:0]      pirq_lvl,
    input  logic [NUM_PIRQ-1:0][7:0] route_q,
    input  logic [NUM_PIRQ-1:0][7:0] route_d,
    input  logic                     route_hit,
    output logic [NUM_IRQ-1:0]       irq_out
);
    localparam int CELLS = NUM_PIRQ * NUM_IRQ;

    upd_kind_e           kind;
    logic [CELLS-1:0]    mtx_q, mtx_d;
    logic [NUM_PIRQ-1:0] lvl_q;

    // Select the update kind; a routing write wins over a line change.
    always_comb begin
        if (route_hit)
            kind = UPD_REBUILD;
        else if (pirq_lvl != lvl_q)
            kind = UPD_LINE;
        else
            kind = UPD_HOLD;
    end

    // Cell (irq, line) sits at irq*NUM_PIRQ + line.
    always_comb begin
        mtx_d = mtx_q;
        unique case (kind)
            UPD_REBUILD: begin
                mtx_d = '0;
                for (int p = 0; p < NUM_PIRQ; p++) begin
                    if (int'(route_d[p]) < NUM_IRQ)
                        mtx_d[int'(route_d[p])*NUM_PIRQ + p] = pirq_lvl[p];
                end
            end
            UPD_LINE: begin
                for (int p = 0; p < NUM_PIRQ; p++) begin
                    if (pirq_lvl[p] != lvl_q[p] && int'(route_q[p]) < NUM_IRQ)
                        mtx_d[int'(route_q[p])*NUM_PIRQ + p] = pirq_lvl[p];
                end
            end
            UPD_HOLD: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mtx_q <= '0;
            lvl_q <= '0;
        end else begin
            mtx_q <= mtx_d;
            lvl_q <= pirq_lvl;
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_IRQ; k++)
            irq_out[k] = |mtx_q[k*NUM_PIRQ +: NUM_PIRQ];
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int         NUM_SLOTS  = 4,
    parameter int         DEV_BASE   = 1,
    parameter int         NUM_PIRQ   = PIRQ_COUNT,
    parameter int         NUM_IRQ    = IRQ_COUNT,
    parameter logic [7:0] ROUTE_ADDR = 8'h60,
    localparam int        SEL_W      = $clog2(NUM_PIRQ),
    localparam int        IRQ_W      = $clog2(NUM_IRQ)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [7:0]                    cfg_addr,
    input  logic [3:0]                    cfg_be,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    input  logic [NUM_SLOTS*NUM_PIRQ-1:0] intx_in,
    input  logic [SEL_W-1:0]              route_sel,
    output logic                          route_on,
    output logic [IRQ_W:0]                route_irq,
    output logic [NUM_IRQ-1:0]            irq_out
);
    logic [NUM_PIRQ-1:0]      pirq_lvl;
    logic [NUM_PIRQ-1:0][7:0] route_q, route_d;
    logic                     route_hit;
    logic [NUM_PIRQ*8-1:0]    route_flat;
    logic [7:0]               qsel;

    pirq_swizzle #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_PIRQ(NUM_PIRQ), .DEV_BASE(DEV_BASE)
    ) u_swizzle (
        .intx_in (intx_in),
        .pirq_lvl(pirq_lvl)
    );

    pirq_route_regs #(
        .NUM_PIRQ(NUM_PIRQ), .ROUTE_ADDR(ROUTE_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_be   (cfg_be),
        .cfg_wdata(cfg_wdata),
        .route_q  (route_q),
        .route_d  (route_d),
        .route_hit(route_hit),
        .cfg_rdata(cfg_rdata)
    );

    pirq_level_matrix #(
        .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)
    ) u_matrix (
        .clk      (clk),
        .rst_n    (rst_n),
        .pirq_lvl (pirq_lvl),
        .route_q  (route_q),
        .route_d  (route_d),
        .route_hit(route_hit),
        .irq_out  (irq_out)
    );

    assign route_flat = route_q;

    // Route query: disabled lines report all ones (-1).
    assign qsel      = route_q[route_sel];
    assign route_on  = int'(qsel) < NUM_IRQ;
    assign route_irq = route_on ? {1'b0, qsel[IRQ_W-1:0]} : '1;
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
    parameter int         NUM_PIRQ   = 4,
    parameter int         NUM_IRQ    = 16,
    parameter logic [7:0] ROUTE_ADDR = 8'h60
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr,
    input logic [7:0]            cfg_addr,
    input logic [3:0]            cfg_be,
    input logic [31:0]           cfg_wdata,
    input logic [NUM_IRQ-1:0]    irq_out,
    input logic [NUM_PIRQ*8-1:0] route_flat,
    input logic [NUM_PIRQ-1:0]   pirq_lvl
);
    logic [NUM_PIRQ-1:0] lvl_prev;
    logic [NUM_IRQ-1:0]  model_irq, routed_any;

    always_ff @(posedge clk) lvl_prev <= pirq_lvl;

    always_comb begin
        for (int k = 0; k < NUM_IRQ; k++) begin
            model_irq[k]  = 1'b0;
            routed_any[k] = 1'b0;
            for (int p = 0; p < NUM_PIRQ; p++) begin
                if (int'(route_flat[p*8 +: 8]) == k) begin
                    routed_any[k] = 1'b1;
                    model_irq[k]  = model_irq[k] | lvl_prev[p];
                end
            end
        end
    end

    assert_reset_defaults_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (route_flat == {NUM_PIRQ{8'h80}} && irq_out == '0));

    // R5, R6, R7: outputs follow last cycle's line levels under present routes.
    assert_irq_model_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == model_irq);

    for (genvar gk = 0; gk < NUM_IRQ; gk++) begin : g_irq
        assert_unrouted_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[gk] |-> routed_any[gk]);
    end

    for (genvar gp = 0; gp < NUM_PIRQ; gp++) begin : g_lane
        assert_lane_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && cfg_addr == ROUTE_ADDR && cfg_be[gp])
            |=> route_flat[gp*8 +: 8] == $past(cfg_wdata[gp*8 +: 8]));
        assert_lane_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_wr && cfg_addr == ROUTE_ADDR && cfg_be[gp])
            |=> $stable(route_flat[gp*8 +: 8]));
    end
endmodule

bind pirq_router pirq_router_chk #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .ROUTE_ADDR(ROUTE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .irq_out   (irq_out),
    .route_flat(route_flat),
    .pirq_lvl  (pirq_lvl)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h60;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic [15:0] intx_in = 16'h0;
    logic [1:0]  route_sel = 2'd0;
    logic        route_on;
    logic [4:0]  route_irq;
    logic [15:0] irq_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [7:0]  rt [4];
    logic [15:0] cur_pins = 16'h0;

    int          q_due [$];
    logic [15:0] q_exp [$];
    string       q_tag [$];

    pirq_router u_pirq_router (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .intx_in(intx_in), .route_sel(route_sel), .route_on(route_on),
        .route_irq(route_irq), .irq_out(irq_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Swizzle per R4, wired-OR per R5, disable per R3.
    function automatic logic [15:0] model_irq();
        logic [3:0]  lv = '0;
        logic [15:0] r  = '0;
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 4; i++)
                if (cur_pins[s*4+i]) lv[(i + (s + 1) - 1) % 4] = 1'b1;
        for (int p = 0; p < 4; p++)
            if (lv[p] && rt[p] < 8'd16) r[rt[p][3:0]] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] model_rdata(input logic [7:0] a);
        return (a == 8'h60) ? {rt[3], rt[2], rt[1], rt[0]} : 32'h0;
    endfunction

    task automatic step(input string tag, input bit wr, input logic [7:0] addr,
                        input logic [3:0] be, input logic [31:0] data,
                        input logic [15:0] pins, input logic [1:0] sel);
        @(negedge clk);
        cfg_wr = wr; cfg_addr = addr; cfg_be = be; cfg_wdata = data;
        intx_in = pins; route_sel = sel;
        #1;
        chk("R2 readback", cfg_rdata, model_rdata(addr));
        chk("R3 query enable", {31'b0, route_on}, {31'b0, rt[sel] < 8'd16});
        chk("R3 query irq", {27'b0, route_irq},
            {27'b0, (rt[sel] < 8'd16) ? {1'b0, rt[sel][3:0]} : 5'h1F});
        if (wr && addr == 8'h60)
            for (int l = 0; l < 4; l++) if (be[l]) rt[l] = data[l*8 +: 8];
        cur_pins = pins;
        q_due.push_back(cyc + 1);
        q_exp.push_back(model_irq());
        q_tag.push_back(tag);
    endtask

    // Monitor: expected outputs fall due one rising edge after the drive.
    always @(negedge clk) begin
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            chk(q_tag[0], {16'b0, irq_out}, {16'b0, q_exp[0]});
            void'(q_due.pop_front());
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 4; p++) rt[p] = 8'h80;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset outputs", {16'b0, irq_out}, 32'h0);
        chk("R1 reset routes", cfg_rdata, 32'h80808080);
        chk("R1 reset query enable", {31'b0, route_on}, 32'h0);
        chk("R1 reset query irq", {27'b0, route_irq}, 32'h1F);

        step("R3 disabled line silent", 0, 8'h60, 4'h0, 32'h0, 16'h0001, 2'd0);
        step("R7 enable A to 5", 1, 8'h60, 4'h1, 32'hAAAAAA05, 16'h0001, 2'd0);
        step("R2 hold", 0, 8'h60, 4'h0, 32'h0, 16'h0001, 2'd0);
        step("R2 lane B only", 1, 8'h60, 4'h2, 32'h03030303, 16'h0001, 2'd1);
        step("R4 slot1 pinA to B", 0, 8'h60, 4'h0, 32'h0, 16'h0011, 2'd1);
        step("R4 slot3 pinA to D", 0, 8'h60, 4'h0, 32'h0, 16'h1001, 2'd3);
        step("R7 enable D to 9", 1, 8'h60, 4'h8, 32'h09000000, 16'h1001, 2'd3);
        step("R5 C shares 5", 1, 8'h60, 4'h4, 32'h00050000, 16'h1101, 2'd2);
        step("R5 shared held by C", 0, 8'h60, 4'h0, 32'h0, 16'h1100, 2'd2);
        step("R5 shared released", 0, 8'h60, 4'h0, 32'h0, 16'h1000, 2'd2);
        step("R6 B rises", 0, 8'h60, 4'h0, 32'h0, 16'h1010, 2'd1);
        step("R7 reroute B to 12", 1, 8'h60, 4'h2, 32'h00000C00, 16'h1010, 2'd1);
        step("R3 B set to 16", 1, 8'h60, 4'h2, 32'h00001000, 16'h1010, 2'd1);
        step("R3 B set to 15", 1, 8'h60, 4'h2, 32'h00000F00, 16'h1010, 2'd1);
        step("R8 other address", 1, 8'h64, 4'hF, 32'h00000000, 16'h1010, 2'd1);
        step("R8 no enables", 1, 8'h60, 4'h0, 32'h00000000, 16'h1010, 2'd1);
        step("R8 unaligned address", 1, 8'h61, 4'hF, 32'h00000000, 16'h1010, 2'd0);
        step("R4 slot0 pinB to B", 0, 8'h60, 4'h0, 32'h0, 16'h1012, 2'd1);
        step("R6 B held by slot0", 0, 8'h60, 4'h0, 32'h0, 16'h1002, 2'd1);
        step("R6 B falls", 0, 8'h60, 4'h0, 32'h0, 16'h1000, 2'd3);
        step("R6 D falls", 0, 8'h60, 4'h0, 32'h0, 16'h0000, 2'd0);
        cfg_wr = 1'b0;

        repeat (3) @(negedge clk);
        if (q_due.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R6 pending expectations actual=%0d expected=0", q_due.size());
        end
        finish_run();
    end
endmodule